// File: doc/BRIEF.md
# Instruction Execution Time Accumulator

This block keeps a running count of processor states for a stream of retired instructions. Each retire pulse comes with the instruction's class code, its branch outcome, its length (two or four bytes), where it was fetched from, the length of one external bus cycle in states, and a count of operand-dependent extra states worked out elsewhere. From these the block computes the time that instruction takes and adds it to a total.

The minimum time starts from the instruction's cost when fetched from internal ROM. A fetch from internal RAM adds a fixed penalty that depends on the instruction length. A fetch from external memory replaces the two fetch states with one or two bus cycles, and this count doubles on a byte-wide bus. Conditional branch and call classes cost two more states when the condition fails. The total starts from a six-state pipeline-fill offset. It returns to that offset on reset or on a synchronous clear, and it saturates instead of wrapping.

Top module: `exec_time_acc`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, `total` equals 6. `clr` takes priority over a `retire` in the same cycle.
- R2: For a ROM fetch (`src`=0) with `taken`=1 and `extra`=0, `insn_time` is 10 for class 1 (multiply), 20 for class 2 (divide), 4 for classes 3 to 10 (conditional call, unconditional call, bit branch, far jump, conditional jump, indexed long-offset move, return, trap), and 2 for class 0.
- R3: For classes 3, 5 and 7, `taken`=0 adds 2 states. For every other class `taken` has no effect on `insn_time`.
- R4: A RAM fetch (`src`=1) adds 4 states to the ROM minimum when `len4`=0 and 6 states when `len4`=1.
- R5: An external 16-bit fetch (`src`=2) costs `bus_states` times 1 (`len4`=0) or times 2 (`len4`=1), plus the ROM minimum minus 2.
- R6: An external 8-bit fetch (`src`=3) uses twice the bus-cycle count of R5.
- R7: `insn_time` equals the minimum from R2 to R6 plus `extra`.
- R8: On each clock edge with `retire`=1 and `clr`=0, `total` grows by `insn_time`. Without `retire`, `total` holds its value.
- R9: When the sum would exceed 2^TOTAL_W−1, `total` stays at 2^TOTAL_W−1.
- R10: Class codes 11 to 15 cost the same as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous reload of the total to the offset |
| retire | input | 1 | One instruction retires this cycle |
| cls | input | 4 | Instruction class code |
| taken | input | 1 | Branch condition met (1) or failed (0) |
| len4 | input | 1 | Instruction is four bytes (1) or two bytes (0) |
| src | input | 2 | Fetch source: 0 ROM, 1 RAM, 2 external 16-bit, 3 external 8-bit |
| bus_states | input | BUS_W | States per external bus cycle |
| extra | input | EXTRA_W | Operand-dependent extra states |
| insn_time | output | INSN_W | States for the presented instruction |
| total | output | TOTAL_W | Accumulated state count |

## Verification
The bench builds the block with TOTAL_W=12, BUS_W=5 and EXTRA_W=4. The narrow total lets a run of slow external byte-bus fetches, about 140 states each, reach the saturation ceiling of 4095 within a few dozen retires. A bus length of up to 31 and extra counts of up to 15 drive the widest per-instruction values, up to 157 states. Random mixes of every class, source, length and outcome are checked against a reference formula in the bench.

// File: rtl/exec_time_acc.sv
module exec_time_acc #(
  parameter int TOTAL_W   = 32,
  parameter int BUS_W     = 5,
  parameter int EXTRA_W   = 4,
  parameter int PIPE_FILL = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               retire,
  input  logic [3:0]         cls,
  input  logic               taken,
  input  logic               len4,
  input  logic [1:0]         src,
  input  logic [BUS_W-1:0]   bus_states,
  input  logic [EXTRA_W-1:0] extra,
  output logic [((BUS_W > EXTRA_W) ? BUS_W : EXTRA_W)+2:0] insn_time,
  output logic [TOTAL_W-1:0] total
);
  localparam int INSN_W = ((BUS_W > EXTRA_W) ? BUS_W : EXTRA_W) + 3;
  localparam logic [TOTAL_W-1:0] T_MAX  = '1;
  localparam logic [TOTAL_W-1:0] T_INIT = TOTAL_W'(PIPE_FILL);

  localparam logic [3:0] C_MUL   = 4'd1;
  localparam logic [3:0] C_DIV   = 4'd2;
  localparam logic [3:0] C_CALLC = 4'd3;
  localparam logic [3:0] C_BITJ  = 4'd5;
  localparam logic [3:0] C_JMPC  = 4'd7;
  localparam logic [3:0] C_LONG0 = 4'd3;
  localparam logic [3:0] C_LONG1 = 4'd10;

  localparam logic [1:0] S_ROM = 2'd0;
  localparam logic [1:0] S_RAM = 2'd1;
  localparam logic [1:0] S_X16 = 2'd2;

  logic [INSN_W-1:0] rom_base, rom_min, fetch_min, bus_mult;
  logic              cond_cls;

  always_comb begin
    if (cls == C_MUL)                          rom_base = INSN_W'(10);
    else if (cls == C_DIV)                     rom_base = INSN_W'(20);
    else if (cls >= C_LONG0 && cls <= C_LONG1) rom_base = INSN_W'(4);
    else                                       rom_base = INSN_W'(2);
  end

  assign cond_cls = (cls == C_CALLC) || (cls == C_BITJ) || (cls == C_JMPC);
  assign rom_min  = rom_base + ((cond_cls && !taken) ? INSN_W'(2) : INSN_W'(0));

  assign bus_mult = INSN_W'(bus_states) << ({1'b0, len4} + ((src == S_X16) ? 2'd0 : 2'd1));

  always_comb begin
    case (src)
      S_ROM:   fetch_min = rom_min;
      S_RAM:   fetch_min = rom_min + (len4 ? INSN_W'(6) : INSN_W'(4));
      default: fetch_min = bus_mult + rom_min - INSN_W'(2);
    endcase
  end

  assign insn_time = fetch_min + INSN_W'(extra);

  logic [TOTAL_W:0] sum_w;
  assign sum_w = {1'b0, total} + (TOTAL_W+1)'(insn_time);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      total <= T_INIT;
    else if (clr)    total <= T_INIT;
    else if (retire) total <= sum_w[TOTAL_W] ? T_MAX : sum_w[TOTAL_W-1:0];
  end

  // R1
  clear_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> total == T_INIT);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !retire) |=> $stable(total));

  // R8
  no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && retire) |=> total >= $past(total));

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && retire && total == T_MAX) |=> total == T_MAX);

  // R7
  extra_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_time >= INSN_W'(extra));
endmodule

// File: tb/exec_time_acc_bench.sv
`timescale 1ns/1ps
module exec_time_acc_bench;
  localparam int TW = 12, BW = 5, EW = 4, IW = 8;
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 0, rst_n = 0, clr = 0, retire = 0, taken = 1, len4 = 0;
  logic [3:0] cls = 0;
  logic [1:0] src = 0;
  logic [BW-1:0] bus_states = 0;
  logic [EW-1:0] extra = 0;
  logic [IW-1:0] insn_time;
  logic [TW-1:0] total;
  int errors = 0, checks = 0, model = 6;
  bit done = 0;

  always #2.5 clk = ~clk;

  exec_time_acc #(.TOTAL_W(TW), .BUS_W(BW), .EXTRA_W(EW)) u_exec_time_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .retire(retire), .cls(cls), .taken(taken),
    .len4(len4), .src(src), .bus_states(bus_states), .extra(extra),
    .insn_time(insn_time), .total(total));

  function automatic int exp_time(int c, int t, int l, int s, int b, int e);
    int r;
    r = (c == 1) ? 10 : (c == 2) ? 20 : (c >= 3 && c <= 10) ? 4 : 2;
    if ((c == 3 || c == 5 || c == 7) && t == 0) r += 2;
    case (s)
      0: return r + e;
      1: return r + (l ? 6 : 4) + e;
      2: return (l ? 2 : 1) * b + r - 2 + e;
      default: return (l ? 4 : 2) * b + r - 2 + e;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(string req, int c, int t, int l, int s, int b, int e, bit r);
    @(negedge clk);
    cls = 4'(c); taken = t[0]; len4 = l[0]; src = 2'(s);
    bus_states = BW'(b); extra = EW'(e); retire = r;
    #1 chk(req, int'(insn_time), exp_time(c, t, l, s, b, e));
    if (r) begin
      model = model + exp_time(c, t, l, s, b, e);
      if (model > TMAX) model = TMAX;
    end
    @(posedge clk); #1 retire = 0;
    chk({req, " total"}, int'(total), model);
  endtask

  task automatic do_clear(bit with_retire);
    @(negedge clk); clr = 1; retire = with_retire;
    @(posedge clk); #1 clr = 0; retire = 0;
    model = 6;
    chk("R1 clear", int'(total), 6);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset", int'(total), 6);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset hold", int'(total), 6);
    for (int c = 0; c < 16; c++)
      apply((c > 10) ? "R10 class" : "R2 class", c, 1, 0, 0, 0, 0, 1);
    for (int c = 0; c < 16; c++) apply("R3 not taken", c, 0, 0, 0, 0, 0, 0);
    apply("R4 ram len2", 1, 1, 0, 1, 0, 0, 1);
    apply("R4 ram len4", 7, 0, 1, 1, 0, 0, 1);
    apply("R5 ext16 len2", 0, 1, 0, 2, 3, 0, 1);
    apply("R5 ext16 len4", 2, 1, 1, 2, 7, 0, 1);
    apply("R6 ext8 len2", 4, 1, 0, 3, 3, 0, 1);
    apply("R6 ext8 len4", 5, 0, 1, 3, 31, 0, 1);
    apply("R7 extra", 0, 1, 0, 0, 0, 15, 1);
    apply("R7 extra ext", 2, 1, 1, 3, 31, 15, 1);
    apply("R8 idle hold", 2, 1, 1, 3, 31, 15, 0);
    do_clear(1);
    for (int i = 0; i < 20; i++)
      apply("R8 random", $urandom % 16, $urandom % 2, $urandom % 2, $urandom % 4,
            $urandom % 8, $urandom % 4, ($urandom % 4) != 0);
    do_clear(0);
    for (int i = 0; i < 32; i++) apply("R9 saturate", 2, 1, 1, 3, 31, 15, 1);
    chk("R9 ceiling", int'(total), TMAX);
    do_clear(0);
    for (int i = 0; i < 120; i++)
      apply("R7 random", $urandom % 16, $urandom % 2, $urandom % 2, $urandom % 4,
            $urandom % 32, $urandom % 16, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule